// File: doc/BRIEF.md
# Partition-Tagged Fully Associative Translation Buffer

This block holds a small set of page translations. Every entry carries a tag made of four parts: a partition number, a flag that marks it as a real-address (rather than virtual-address) mapping, a context number and the number of an 8 KiB page. A lookup presents the same four parts and, one clock later, gets back a hit flag, the index of the matching entry and its physical page number. If more than one entry matches, a separate flag is also raised.

New translations arrive on an insert port. The block picks the slot to overwrite, steered by a per-entry used bit, and software can protect an entry with a lock bit. A maintenance port removes entries in four ways: the whole array, everything unlocked in one partition, one context within a partition, or one page. A combinational diagnostic port returns the packed tag word and data word of any entry by index.

Top module: `ptlb`

## Requirements
- R1: A virtual lookup (`lk_real`=0) hits an entry only when the entry is valid, its real flag is clear, and its partition, context and page number all equal the request's.
- R2: A real lookup (`lk_real`=1) hits a valid entry whose real flag is set and whose partition and page number match. The context of both request and entry takes no part in the match.
- R3: Address bits 12..0 never take part in a compare. Only `va[47:13]` forms the page number, for lookup, insert and page demap alike.
- R4: Maintenance opcode 0 (flush) clears the valid bit of every entry, locked ones included.
- R5: Opcode 1 (partition demap) clears the valid entries whose partition matches `mnt_pid` and whose lock bit is 0. Locked entries stay valid.
- R6: Opcode 2 (context demap) clears every entry whose partition and context both match, regardless of its lock and real flags.
- R7: Opcode 3 (page demap) clears entries that match partition, real flag and page number. For a virtual command (`mnt_real`=0) the context must also match.
- R8: Lookup results appear on `lk_hit`, `lk_idx`, `lk_ppn` and `lk_multi` on the clock edge after the request and are computed from the table as it was before that edge. A cycle with no request, or with a miss, gives `lk_hit`=0, `lk_idx`=0 and `lk_ppn`=0.
- R9: When several entries match a lookup, the lowest index is reported and `lk_multi`=1.
- R10: An insert writes the lowest-index invalid entry if there is one.
- R11: When every entry is valid, an insert writes the lowest-index entry that is neither used nor locked, and entry ENTRIES-1 if there is none. A hit or an insert sets the entry's used bit. If, after that, every valid entry is used, all used bits except those just set are cleared. Clearing an entry also clears its used bit.
- R12: A maintenance command takes effect on the edge at which it is presented. An insert presented in the same cycle is dropped.
- R13: `dg_tag` = {valid, real, pid[2:0], ctx[12:0], vpn[34:0]} and `dg_data` = {lock, ppn[27:0]} of entry `dg_idx`, taken combinationally from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pid | input | 3 | Lookup partition |
| lk_real | input | 1 | Lookup is real-address |
| lk_ctx | input | 13 | Lookup context |
| lk_va | input | 48 | Lookup address |
| lk_hit | output | 1 | Registered hit |
| lk_idx | output | IDX_W | Registered index of matching entry |
| lk_ppn | output | 28 | Registered physical page number |
| lk_multi | output | 1 | Registered multiple-match flag |
| ins_valid | input | 1 | Insert request |
| ins_pid | input | 3 | Insert partition |
| ins_real | input | 1 | Insert real flag |
| ins_ctx | input | 13 | Insert context |
| ins_va | input | 48 | Insert address |
| ins_ppn | input | 28 | Insert physical page number |
| ins_lock | input | 1 | Insert lock bit |
| mnt_valid | input | 1 | Maintenance command valid |
| mnt_op | input | 2 | 0 flush, 1 partition, 2 context, 3 page |
| mnt_pid | input | 3 | Command partition |
| mnt_real | input | 1 | Command real flag (page demap) |
| mnt_ctx | input | 13 | Command context |
| mnt_va | input | 48 | Command address (page demap) |
| dg_idx | input | IDX_W | Diagnostic entry index |
| dg_tag | output | 53 | Diagnostic tag word |
| dg_data | output | 29 | Diagnostic data word |

## Verification
The assertions assume reset is applied before traffic starts, that `mnt_op` is always one of the four defined codes while `mnt_valid` is high, and that an insert never targets a full table unless the replacement rule is meant to be exercised. The stimulus draws partition, context and page numbers from small ranges so that hits, duplicate entries and multiple matches happen often. It sets the low 13 address bits at random to cover the page-offset rule, and it keeps maintenance commands rare enough that the table fills and the used-bit wrap runs repeatedly.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int PID_W      = 3;
  localparam int CTX_W      = 13;
  localparam int VA_W       = 48;
  localparam int PAGE_SHIFT = 13;
  localparam int VPN_W      = VA_W - PAGE_SHIFT;
  localparam int PPN_W      = 28;
  localparam int TAG_W      = 2 + PID_W + CTX_W + VPN_W;
  localparam int DATA_W     = 1 + PPN_W;

  typedef logic [PID_W-1:0] pid_t;
  typedef logic [CTX_W-1:0] ctx_t;
  typedef logic [VPN_W-1:0] vpn_t;
  typedef logic [PPN_W-1:0] ppn_t;
  typedef logic [VA_W-1:0]  va_t;

  typedef enum logic [1:0] {
    MNT_FLUSH = 2'd0,
    MNT_PART  = 2'd1,
    MNT_CTX   = 2'd2,
    MNT_PAGE  = 2'd3
  } mnt_op_e;

  typedef struct packed {
    logic valid;
    logic lock;
    logic is_real;
    pid_t pid;
    ctx_t ctx;
    vpn_t vpn;
    ppn_t ppn;
  } ent_t;

  function automatic vpn_t page_of(input va_t va);
    return va[VA_W-1:PAGE_SHIFT];
  endfunction

  function automatic logic lookup_match(input ent_t e, input pid_t pid,
                                        input logic rl, input ctx_t ctx,
                                        input vpn_t vpn);
    logic ctx_ok;
    ctx_ok = rl ? 1'b1 : (e.ctx == ctx);
    return e.valid && (e.pid == pid) && (e.is_real == rl) &&
           (e.vpn == vpn) && ctx_ok;
  endfunction

  function automatic logic demap_match(input ent_t e, input mnt_op_e op,
                                       input pid_t pid, input logic rl,
                                       input ctx_t ctx, input vpn_t vpn);
    logic m;
    case (op)
      MNT_FLUSH: m = 1'b1;
      MNT_PART:  m = (e.pid == pid) && !e.lock;
      MNT_CTX:   m = (e.pid == pid) && (e.ctx == ctx);
      default:   m = (e.pid == pid) && (e.is_real == rl) && (e.vpn == vpn) &&
                     (rl || (e.ctx == ctx));
    endcase
    return e.valid && m;
  endfunction

  function automatic logic [TAG_W-1:0] tag_word(input ent_t e);
    return {e.valid, e.is_real, e.pid, e.ctx, e.vpn};
  endfunction

  function automatic logic [DATA_W-1:0] data_word(input ent_t e);
    return {e.lock, e.ppn};
  endfunction
endpackage

// File: rtl/ptlb_match.sv
module ptlb_match
  import ptlb_pkg::*;
#(
  parameter int N = 8
) (
  input  ent_t         ents [N],
  input  pid_t         q_pid,
  input  logic         q_real,
  input  ctx_t         q_ctx,
  input  vpn_t         q_vpn,
  output logic [N-1:0] hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = lookup_match(ents[i], q_pid, q_real, q_ctx, q_vpn);
  end
endmodule

// File: rtl/ptlb_pick.sv
module ptlb_pick #(
  parameter int N    = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic          multi
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any   = |req;
  assign multi = |(req & (req - 1'b1));
endmodule

// File: rtl/ptlb_victim.sv
module ptlb_victim #(
  parameter int N    = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]  valid,
  input  logic [N-1:0]  used,
  input  logic [N-1:0]  lock,
  output logic [IW-1:0] idx
);
  logic [N-1:0]  free_v;
  logic [N-1:0]  cold_v;
  logic          free_any;
  logic          cold_any;
  logic          free_multi;
  logic          cold_multi;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] cold_idx;

  assign free_v = ~valid;
  assign cold_v = ~used & ~lock;

  ptlb_pick #(.N(N)) u_free (.req(free_v), .any(free_any), .idx(free_idx), .multi(free_multi));
  ptlb_pick #(.N(N)) u_cold (.req(cold_v), .any(cold_any), .idx(cold_idx), .multi(cold_multi));

  logic unused_ok;
  assign unused_ok = free_multi ^ cold_multi;

  always_comb begin
    if (free_any)      idx = free_idx;
    else if (cold_any) idx = cold_idx;
    else               idx = IW'(N - 1);
  end
endmodule

// File: rtl/ptlb.sv
module ptlb
  import ptlb_pkg::*;
#(
  parameter int  ENTRIES = 8,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic              lk_real,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              lk_multi,
  input  logic              ins_valid,
  input  logic [PID_W-1:0]  ins_pid,
  input  logic              ins_real,
  input  logic [CTX_W-1:0]  ins_ctx,
  input  logic [VA_W-1:0]   ins_va,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic              ins_lock,
  input  logic              mnt_valid,
  input  logic [1:0]        mnt_op,
  input  logic [PID_W-1:0]  mnt_pid,
  input  logic              mnt_real,
  input  logic [CTX_W-1:0]  mnt_ctx,
  input  logic [VA_W-1:0]   mnt_va,
  input  logic [IDX_W-1:0]  dg_idx,
  output logic [TAG_W-1:0]  dg_tag,
  output logic [DATA_W-1:0] dg_data
);
  ent_t               ents [ENTRIES];
  logic [ENTRIES-1:0] used_q;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] lock_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_vec
    assign valid_vec[i] = ents[i].valid;
    assign lock_vec[i]  = ents[i].lock;
  end

  // lookup compare and priority
  logic [ENTRIES-1:0] hit_vec;
  logic               hit_any;
  logic               hit_multi;
  logic [IDX_W-1:0]   hit_idx;

  ptlb_match #(.N(ENTRIES)) u_match (
    .ents(ents), .q_pid(lk_pid), .q_real(lk_real), .q_ctx(lk_ctx),
    .q_vpn(page_of(lk_va)), .hit(hit_vec)
  );

  ptlb_pick #(.N(ENTRIES)) u_hitpick (
    .req(hit_vec), .any(hit_any), .idx(hit_idx), .multi(hit_multi)
  );

  wire lk_take = lk_valid && hit_any;

  // maintenance clear mask
  mnt_op_e            op_e;
  logic [ENTRIES-1:0] mnt_clr;
  assign op_e = mnt_op_e'(mnt_op);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_dm
    assign mnt_clr[i] = mnt_valid &&
      demap_match(ents[i], op_e, mnt_pid, mnt_real, mnt_ctx, page_of(mnt_va));
  end

  // insert slot choice
  logic [IDX_W-1:0]   vic_idx;
  logic               ins_go;
  logic [ENTRIES-1:0] ins_oh;

  ptlb_victim #(.N(ENTRIES)) u_victim (
    .valid(valid_vec), .used(used_q), .lock(lock_vec), .idx(vic_idx)
  );

  assign ins_go = ins_valid && !mnt_valid;
  assign ins_oh = ins_go ? (ENTRIES'(1) << vic_idx) : '0;

  ent_t new_ent;
  always_comb begin
    new_ent         = '0;
    new_ent.valid   = 1'b1;
    new_ent.lock    = ins_lock;
    new_ent.is_real = ins_real;
    new_ent.pid     = ins_pid;
    new_ent.ctx     = ins_ctx;
    new_ent.vpn     = page_of(ins_va);
    new_ent.ppn     = ins_ppn;
  end

  // used-bit bookkeeping for replacement
  logic [ENTRIES-1:0] hit_oh;
  logic [ENTRIES-1:0] touch;
  logic [ENTRIES-1:0] valid_nxt;
  logic [ENTRIES-1:0] used_set;
  logic               used_wrap;
  logic [ENTRIES-1:0] used_nxt;

  assign hit_oh    = lk_take ? (ENTRIES'(1) << hit_idx) : '0;
  assign touch     = (hit_oh & ~mnt_clr) | ins_oh;
  assign valid_nxt = (valid_vec & ~mnt_clr) | ins_oh;
  assign used_set  = (used_q & ~mnt_clr) | touch;
  assign used_wrap = (|touch) && ((used_set & valid_nxt) == valid_nxt);
  assign used_nxt  = (used_wrap ? touch : used_set) & valid_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
      used_q   <= '0;
      lk_hit   <= 1'b0;
      lk_idx   <= '0;
      lk_ppn   <= '0;
      lk_multi <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ins_oh[i])       ents[i]       <= new_ent;
        else if (mnt_clr[i]) ents[i].valid <= 1'b0;
      end
      used_q   <= used_nxt;
      lk_hit   <= lk_take;
      lk_idx   <= lk_take ? hit_idx : '0;
      lk_ppn   <= lk_take ? ents[hit_idx].ppn : '0;
      lk_multi <= lk_valid && hit_multi;
    end
  end

  assign dg_tag  = tag_word(ents[dg_idx]);
  assign dg_data = data_word(ents[dg_idx]);
endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lk_valid,
  input logic         lk_hit,
  input logic         lk_multi,
  input logic         mnt_valid,
  input logic [1:0]   mnt_op,
  input logic         ins_go,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] lock_q,
  input logic [N-1:0] used_q
);
  a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_valid && mnt_op == 2'd0) |=> (valid_q == '0));

  a_r5_lock_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_valid && mnt_op == 2'd1) |=> (($past(valid_q & lock_q) & ~valid_q) == '0));

  a_r12_mnt_blocks_insert: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_valid |=> ((valid_q & ~$past(valid_q)) == '0));

  a_r8_no_req_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_hit);

  a_r9_multi_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);

  a_r10_fill_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_go && !(&valid_q)) |=> ($countones(valid_q) == $countones($past(valid_q)) + 1));

  a_r11_used_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ((used_q & ~valid_q) == '0));
endmodule

bind ptlb ptlb_chk #(.N(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_multi(lk_multi), .mnt_valid(mnt_valid), .mnt_op(mnt_op),
  .ins_go(ins_go), .valid_q(valid_vec), .lock_q(lock_vec), .used_q(used_q)
);

// File: tb/ptlb_tb.sv
module ptlb_tb;
  localparam int N = 8;

  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic        lk_valid = 0, lk_real = 0;
  logic [2:0]  lk_pid = 0;
  logic [12:0] lk_ctx = 0;
  logic [47:0] lk_va = 0;
  logic        lk_hit, lk_multi;
  logic [2:0]  lk_idx;
  logic [27:0] lk_ppn;
  logic        ins_valid = 0, ins_real = 0, ins_lock = 0;
  logic [2:0]  ins_pid = 0;
  logic [12:0] ins_ctx = 0;
  logic [47:0] ins_va = 0;
  logic [27:0] ins_ppn = 0;
  logic        mnt_valid = 0, mnt_real = 0;
  logic [1:0]  mnt_op = 0;
  logic [2:0]  mnt_pid = 0;
  logic [12:0] mnt_ctx = 0;
  logic [47:0] mnt_va = 0;
  logic [2:0]  dg_idx = 0;
  logic [52:0] dg_tag;
  logic [28:0] dg_data;

  ptlb #(.ENTRIES(N)) u_dut (.*);

  // reference table
  logic        m_v [N], m_l [N], m_r [N], m_u [N];
  logic [2:0]  m_pid [N];
  logic [12:0] m_ctx [N];
  logic [34:0] m_vpn [N];
  logic [27:0] m_ppn [N];

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [34:0] pg(input logic [47:0] va);
    return va >> 13;
  endfunction

  function automatic logic [47:0] mkva(input int vpn, input int off);
    return (48'(vpn) << 13) | 48'(off & 13'h1fff);
  endfunction

  function automatic bit hits(input int i);
    if (!m_v[i] || m_pid[i] != lk_pid || m_r[i] != lk_real) return 0;
    if (m_vpn[i] != pg(lk_va)) return 0;
    return lk_real || (m_ctx[i] == lk_ctx);
  endfunction

  function automatic bit drops(input int i);
    if (!m_v[i]) return 0;
    if (mnt_op == 0) return 1;
    if (m_pid[i] != mnt_pid) return 0;
    if (mnt_op == 1) return !m_l[i];
    if (mnt_op == 2) return m_ctx[i] == mnt_ctx;
    return m_r[i] == mnt_real && m_vpn[i] == pg(mnt_va) &&
           (mnt_real || m_ctx[i] == mnt_ctx);
  endfunction

  function automatic int slot();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 0; i < N; i++) if (!m_u[i] && !m_l[i]) return i;
    return N - 1;
  endfunction

  // one clock of traffic, reference update and registered-result check
  task automatic cycle(input string req);
    logic [32:0] exp;
    bit          clr [N], tch [N];
    int          cnt, first;
    bit          all_used, any_t;
    cnt = 0; first = 0;
    for (int i = N - 1; i >= 0; i--) if (lk_valid && hits(i)) begin cnt++; first = i; end
    exp = (cnt > 0) ? {1'b1, 3'(first), m_ppn[first], cnt > 1} : 33'd0;
    for (int i = 0; i < N; i++) begin
      clr[i] = mnt_valid && drops(i);
      tch[i] = (cnt > 0) && (i == first) && !clr[i];
    end
    if (ins_valid && !mnt_valid) begin
      int s;
      s = slot();
      m_v[s] = 1; m_l[s] = ins_lock; m_r[s] = ins_real; m_pid[s] = ins_pid;
      m_ctx[s] = ins_ctx; m_vpn[s] = pg(ins_va); m_ppn[s] = ins_ppn;
      tch[s] = 1;
    end
    any_t = 0; all_used = 1;
    for (int i = 0; i < N; i++) begin
      if (clr[i]) begin m_v[i] = 0; m_u[i] = 0; end
      if (tch[i]) begin m_u[i] = 1; any_t = 1; end
      if (m_v[i] && !m_u[i]) all_used = 0;
    end
    if (any_t && all_used)
      for (int i = 0; i < N; i++) m_u[i] = tch[i];
    @(posedge clk);
    @(negedge clk);
    chk(req, "lookup", 64'({lk_hit, lk_idx, lk_ppn, lk_multi}), 64'(exp));
    lk_valid = 0; ins_valid = 0; mnt_valid = 0;
  endtask

  task automatic diag(input string req);
    for (int i = 0; i < N; i++) begin
      dg_idx = 3'(i);
      #1;
      chk(req, "tag", 64'(dg_tag), 64'({m_v[i], m_r[i], m_pid[i], m_ctx[i], m_vpn[i]}));
      chk(req, "data", 64'(dg_data), 64'({m_l[i], m_ppn[i]}));
    end
  endtask

  task automatic do_ins(input int pid, input bit rl, input int ctx, input int vpn,
                        input int ppn, input bit lk, input string req);
    ins_valid = 1; ins_pid = 3'(pid); ins_real = rl; ins_ctx = 13'(ctx);
    ins_va = mkva(vpn, $urandom); ins_ppn = 28'(ppn); ins_lock = lk;
    cycle(req);
  endtask

  task automatic do_lk(input int pid, input bit rl, input int ctx, input int vpn,
                       input int off, input string req);
    lk_valid = 1; lk_pid = 3'(pid); lk_real = rl; lk_ctx = 13'(ctx);
    lk_va = mkva(vpn, off);
    cycle(req);
  endtask

  task automatic set_mnt(input int op, input int pid, input bit rl, input int ctx,
                         input int vpn);
    mnt_valid = 1; mnt_op = 2'(op); mnt_pid = 3'(pid); mnt_real = rl;
    mnt_ctx = 13'(ctx); mnt_va = mkva(vpn, $urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_71b));
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_l[i] = 0; m_r[i] = 0; m_u[i] = 0;
      m_pid[i] = 0; m_ctx[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8", "reset hit", 64'(lk_hit), 64'd0);
    diag("R13");

    // R10: fill free slots in order
    for (int i = 0; i < N; i++) do_ins(1, 0, i, 16 + i, 100 + i, i == 0, "R10");
    diag("R10");

    // R1 / R3: virtual hit with arbitrary page offset, then context mismatch
    do_lk(1, 0, 3, 19, 13'h1abc, "R1");
    do_lk(1, 0, 3, 19, 13'h0001, "R3");
    do_lk(1, 0, 4, 19, 0, "R1");

    // R5: partition demap keeps the locked entry
    set_mnt(1, 1, 0, 0, 0);
    cycle("R5");
    diag("R5");
    do_lk(1, 0, 0, 16, 7, "R5");

    // R2: real translation ignores context
    do_ins(2, 1, 5, 40, 200, 0, "R2");
    do_lk(2, 1, 9, 40, 13'h0fff, "R2");
    do_lk(2, 0, 5, 40, 0, "R2");

    // R6: context demap removes locked entry
    set_mnt(2, 1, 0, 0, 0);
    cycle("R6");
    diag("R6");

    // R7 / R12: page demap with a concurrent insert that must be dropped
    ins_valid = 1; ins_pid = 3; ins_real = 0; ins_ctx = 2; ins_va = mkva(7, 0);
    ins_ppn = 28'd77; ins_lock = 0;
    set_mnt(3, 2, 1, 11, 40);
    cycle("R12");
    diag("R7");

    // R4: flush clears locked entries
    do_ins(4, 0, 1, 3, 300, 1, "R4");
    set_mnt(0, 0, 0, 0, 0);
    cycle("R4");
    diag("R4");

    // R9: duplicate entries give lowest index and multi flag
    do_ins(5, 0, 6, 9, 11, 0, "R9");
    do_ins(5, 0, 6, 9, 22, 0, "R9");
    do_lk(5, 0, 6, 9, 5, "R9");

    // R11: used-bit victim choice, then all-locked fallback
    set_mnt(0, 0, 0, 0, 0);
    cycle("R11");
    for (int i = 0; i < N; i++) do_ins(6, 0, 0, i, 400 + i, 0, "R11");
    do_ins(6, 0, 0, 50, 450, 0, "R11");
    do_lk(6, 0, 0, 1, 0, "R11");
    do_ins(6, 0, 0, 51, 451, 0, "R11");
    diag("R11");
    set_mnt(0, 0, 0, 0, 0);
    cycle("R11");
    for (int i = 0; i < N; i++) do_ins(7, 1, 0, i, 500 + i, 1, "R11");
    do_ins(7, 1, 0, 60, 560, 0, "R11");
    diag("R11");

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      lk_valid = ($urandom_range(0, 9) < 7);
      lk_pid = 3'($urandom_range(0, 3)); lk_real = ($urandom_range(0, 3) == 0);
      lk_ctx = 13'($urandom_range(0, 3)); lk_va = mkva($urandom_range(0, 7), $urandom);
      ins_valid = ($urandom_range(0, 9) < 3);
      ins_pid = 3'($urandom_range(0, 3)); ins_real = ($urandom_range(0, 3) == 0);
      ins_ctx = 13'($urandom_range(0, 3)); ins_va = mkva($urandom_range(0, 7), $urandom);
      ins_ppn = 28'($urandom); ins_lock = ($urandom_range(0, 6) == 0);
      if ($urandom_range(0, 24) < 2)
        set_mnt($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1),
                $urandom_range(0, 3), $urandom_range(0, 7));
      cycle("R8");
      if (n % 50 == 49) diag("R13");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule